// File: doc/BRIEF.md
# PLL output divider clock tree

This block turns one VCO clock into two derived clocks. The byte clock path runs through a programmable post-divider and a fixed halving stage. A glitch-safe select then picks either that halved clock or the undivided VCO clock. A fixed divide-by-four turns the selected clock into the byte clock. The pixel clock comes from a second programmable divider, fed straight from the VCO.

Three small configuration registers hold the two divider ratios and the path select. Software can read all three back and write the same values again later, so a configuration that was saved can be restored unchanged. All divider state is clocked by the VCO clock. A synchronous reset clears the dividers and leaves the configuration registers alone, so the outputs start low and in phase.

Top module: `pll_clk_tree`

## Requirements
- R1: Register address 0 holds the byte-path divider value N in bits 3:0. Reading address 0 returns N with bits 7:4 as zero, and reading address 3 returns zero.
- R2: When the select is 1, the byte clock has a period of 8*(N+1) VCO cycles and is high for 4*(N+1) of them. N=0 gives period 8.
- R3: The path select is bit 1 of address 2, and that address reads back as 0x02 or 0x00. When the select is 0, the byte clock has a period of 4 VCO cycles and is high for 2 of them, whatever N is.
- R4: Address 1 holds the pixel divider value M in bits 7:0. For M of 1 or more, the pixel clock has a period of M+1 VCO cycles and is high for floor(M/2)+1 of them. For M=255 the period is 256.
- R5: With M=0 the pixel clock equals the VCO clock: high in the first half of each cycle and low in the second half.
- R6: A new select value takes effect only at a VCO edge where the halved clock is low. No high pulse of the byte clock is shorter than 2 VCO cycles, even across a select change.
- R7: While the reset is high, the byte clock and the pixel clock (M of 1 or more) are low, and the configuration registers keep their values. With select 0 and M of 1 or more, both clocks rise at the first VCO edge after the reset is released.
- R8: The values read from the three registers can be written back after other values were written. The readback and both output clocks then match what they were before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; clocks all state |
| rst | input | 1 | Synchronous reset of the dividers, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write address (0 byte divider, 1 pixel divider, 2 select) |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 2 | Read address |
| cfg_rdata | output | 8 | Read data, combinational from cfg_raddr |
| byte_clk | output | 1 | Byte clock |
| pix_clk | output | 1 | Pixel clock |

## Verification
Readback is combinational, so the bench reads one time step after it sets the read address. Every registered output changes at a VCO rising edge and is sampled at the following falling edge. The one exception is the undivided pixel clock, which the bench samples 2 ns after each edge. Right after reset, both clocks are checked at the first falling edge after release. A new select value can wait up to 2*(N+1) cycles, and a new ratio up to one old period. For that reason the bench throws away one full measured period before it compares a period or a high time.

// File: rtl/pll_clk_tree.sv
module pll_clk_tree #(
  parameter int BDIV_W = 4,
  parameter int PDIV_W = 8
) (
  input  logic       vco_clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic [1:0] cfg_raddr,
  output logic [7:0] cfg_rdata,
  output logic       byte_clk,
  output logic       pix_clk
);
  localparam logic [1:0] A_BDIV = 2'd0;
  localparam logic [1:0] A_PDIV = 2'd1;
  localparam logic [1:0] A_SEL  = 2'd2;
  localparam logic [BDIV_W-1:0] B_ONE = 1;
  localparam logic [PDIV_W-1:0] P_ONE = 1;

  logic [BDIV_W-1:0] bdiv_n, bcnt;
  logic [PDIV_W-1:0] pdiv_n, pcnt, pcnt_nx, phigh;
  logic [1:0]        qcnt, qcnt_nx;
  logic              sel_reg, sel_eff, half_q, byte_q, pix_q;
  logic              bwrap, src_tick;

  always_ff @(posedge vco_clk)
    if (cfg_we)
      case (cfg_addr)
        A_BDIV:  bdiv_n  <= cfg_wdata[BDIV_W-1:0];
        A_PDIV:  pdiv_n  <= cfg_wdata[PDIV_W-1:0];
        A_SEL:   sel_reg <= cfg_wdata[1];
        default: ;
      endcase

  always_comb
    case (cfg_raddr)
      A_BDIV:  cfg_rdata = 8'(bdiv_n);
      A_PDIV:  cfg_rdata = 8'(pdiv_n);
      A_SEL:   cfg_rdata = {6'd0, sel_reg, 1'b0};
      default: cfg_rdata = 8'd0;
    endcase

  assign bwrap    = (bcnt >= bdiv_n);
  assign src_tick = sel_eff ? (bwrap && !half_q) : 1'b1;
  assign qcnt_nx  = qcnt + {1'b0, src_tick};
  assign pcnt_nx  = (pcnt >= pdiv_n) ? '0 : pcnt + P_ONE;
  assign phigh    = (pdiv_n >> 1) + P_ONE;

  always_ff @(posedge vco_clk) begin
    if (rst) begin
      bcnt    <= '0;
      half_q  <= 1'b0;
      qcnt    <= '0;
      byte_q  <= 1'b0;
      pcnt    <= '0;
      pix_q   <= 1'b0;
      sel_eff <= sel_reg;
    end else begin
      bcnt   <= bwrap ? '0 : bcnt + B_ONE;
      half_q <= half_q ^ bwrap;
      qcnt   <= qcnt_nx;
      byte_q <= (qcnt_nx == 2'd1) || (qcnt_nx == 2'd2);
      pcnt   <= pcnt_nx;
      pix_q  <= (pcnt_nx != '0) && (pcnt_nx <= phigh);
      if (!half_q) sel_eff <= sel_reg;
    end
  end

  assign byte_clk = byte_q;
  assign pix_clk  = (pdiv_n == '0) ? vco_clk : pix_q;
endmodule

module pll_clk_tree_chk #(
  parameter int BDIV_W = 4
) (
  input logic       vco_clk,
  input logic       rst,
  input logic       sel_eff,
  input logic       half_q,
  input logic       byte_q,
  input logic       pix_q,
  input logic [1:0] cfg_raddr,
  input logic [7:0] cfg_rdata
);
  logic [3:0] hrun;

  always_ff @(posedge vco_clk)
    if (rst) hrun <= '0;
    else if (!byte_q) hrun <= '0;
    else if (hrun != 4'hF) hrun <= hrun + 4'd1;

  AST_SEL_SAFE: assert property (@(posedge vco_clk) disable iff (rst)
    (sel_eff != $past(sel_eff)) |-> !$past(half_q)); // R6

  AST_BYTE_NO_RUNT: assert property (@(posedge vco_clk) disable iff (rst)
    (!byte_q && $past(byte_q)) |-> (hrun >= 4'd2)); // R6

  AST_RESET_LOW: assert property (@(posedge vco_clk)
    rst |=> (!byte_q && !pix_q && !half_q)); // R7

  AST_READ_MASK: assert property (@(posedge vco_clk) disable iff (rst)
    (cfg_raddr == 2'd0) |-> ((cfg_rdata >> BDIV_W) == 8'd0)); // R1

  AST_SEL_READ: assert property (@(posedge vco_clk) disable iff (rst)
    (cfg_raddr == 2'd2) |-> ((cfg_rdata & 8'hFD) == 8'd0)); // R3
endmodule

bind pll_clk_tree pll_clk_tree_chk #(.BDIV_W(BDIV_W)) u_chk (
  .vco_clk(vco_clk), .rst(rst), .sel_eff(sel_eff), .half_q(half_q),
  .byte_q(byte_q), .pix_q(pix_q), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_pll_clk_tree.sv
`timescale 1ns/1ps
module sim_pll_clk_tree;
  logic vco_clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0, cfg_raddr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic byte_clk, pix_clk;
  int n_run = 0, n_bad = 0;
  bit done = 0;

  always #5 vco_clk = ~vco_clk;

  pll_clk_tree u0 (.vco_clk(vco_clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .byte_clk(byte_clk), .pix_clk(pix_clk));

  // {N, M, sel, byte period, pixel period}
  localparam logic [30:0] VEC [6] = '{
    {4'd0,  8'd1,   1'b0, 9'd4,   9'd2},
    {4'd0,  8'd2,   1'b1, 9'd8,   9'd3},
    {4'd3,  8'd3,   1'b1, 9'd32,  9'd4},
    {4'd15, 8'd255, 1'b1, 9'd128, 9'd256},
    {4'd2,  8'd4,   1'b0, 9'd4,   9'd5},
    {4'd1,  8'd6,   1'b1, 9'd16,  9'd7}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge vco_clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge vco_clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge vco_clk);
    cfg_raddr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic measure(input bit pick, output int per, output int hi);
    logic p, c;
    bit rise;
    int guard = 0;
    @(negedge vco_clk);
    p = pick ? pix_clk : byte_clk;
    c = p;
    do begin
      @(negedge vco_clk); c = pick ? pix_clk : byte_clk;
      rise = !p && c; p = c; guard++;
    end while (!rise && guard < 2000);
    per = 0; hi = 0;
    do begin
      if (c) hi++;
      per++;
      @(negedge vco_clk); c = pick ? pix_clk : byte_clk;
      rise = !p && c; p = c; guard++;
    end while (!rise && guard < 4000);
  endtask

  task automatic settle_measure(input bit pick, output int per, output int hi);
    int dp, dh;
    measure(pick, dp, dh);
    measure(pick, per, hi);
  endtask

  initial begin
    logic [7:0] d, s0, s1, s2;
    int per, hi, minrun, runlen;
    logic prevb;

    // reset state and phase
    wr(2'd0, 8'd1); wr(2'd1, 8'd3); wr(2'd2, 8'h00);
    repeat (3) @(negedge vco_clk);
    chk(byte_clk == 1'b0, "R7 byte low in reset", byte_clk, 0);
    chk(pix_clk == 1'b0, "R7 pix low in reset", pix_clk, 0);
    rst = 1'b0;
    @(negedge vco_clk);
    chk(byte_clk == 1'b1, "R7 byte rises first edge", byte_clk, 1);
    chk(pix_clk == 1'b1, "R7 pix rises first edge", pix_clk, 1);

    // readback masks
    wr(2'd0, 8'hFF); rd(2'd0, d);
    chk(d == 8'h0F, "R1 byte divider readback", d, 8'h0F);
    wr(2'd3, 8'hA5); rd(2'd3, d);
    chk(d == 8'h00, "R1 unused address reads zero", d, 0);
    wr(2'd2, 8'hFF); rd(2'd2, d);
    chk(d == 8'h02, "R3 select readback", d, 2);
    wr(2'd1, 8'h9C); rd(2'd1, d);
    chk(d == 8'h9C, "R4 pixel divider readback", d, 8'h9C);

    // vector table
    for (int i = 0; i < 6; i++) begin
      logic [3:0] vn; logic [7:0] vm; logic vs; logic [8:0] vb, vp;
      {vn, vm, vs, vb, vp} = VEC[i];
      wr(2'd0, {4'd0, vn}); wr(2'd1, vm); wr(2'd2, {6'd0, vs, 1'b0});
      settle_measure(1'b1, per, hi);
      chk(per == int'(vp), $sformatf("R4 pixel period vec %0d", i), per, vp);
      chk(hi == int'(vm) / 2 + 1, $sformatf("R4 pixel high vec %0d", i), hi, vm / 2 + 1);
      settle_measure(1'b0, per, hi);
      chk(per == int'(vb), $sformatf("%s byte period vec %0d", vs ? "R2" : "R3", i), per, vb);
      chk(hi == int'(vb) / 2, $sformatf("%s byte high vec %0d", vs ? "R2" : "R3", i), hi, vb / 2);
    end

    // undivided pixel clock
    wr(2'd1, 8'd0);
    @(posedge vco_clk); #2;
    chk(pix_clk == 1'b1, "R5 pix high after rise", pix_clk, 1);
    @(negedge vco_clk); #2;
    chk(pix_clk == 1'b0, "R5 pix low after fall", pix_clk, 0);
    @(posedge vco_clk); #2;
    chk(pix_clk == 1'b1, "R5 pix follows vco", pix_clk, 1);

    // select switching without runt pulses
    wr(2'd0, 8'd2); wr(2'd2, 8'h02);
    minrun = 1000; runlen = 0; prevb = byte_clk;
    for (int k = 0; k < 400; k++) begin
      @(negedge vco_clk);
      if (k % 37 == 5) begin cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = (k % 74 == 5) ? 8'h00 : 8'h02; end
      else cfg_we = 1'b0;
      if (byte_clk) runlen++;
      else begin
        if (prevb && runlen < minrun) minrun = runlen;
        runlen = 0;
      end
      prevb = byte_clk;
    end
    cfg_we = 1'b0;
    chk(minrun >= 2, "R6 shortest byte high pulse", minrun, 2);
    wr(2'd2, 8'h00);
    settle_measure(1'b0, per, hi);
    chk(per == 4, "R6 byte period after switch to vco", per, 4);

    // reset retains configuration
    wr(2'd0, 8'd7); wr(2'd1, 8'd9); wr(2'd2, 8'h02);
    @(negedge vco_clk); rst = 1'b1;
    repeat (2) @(negedge vco_clk);
    chk(byte_clk == 1'b0 && pix_clk == 1'b0, "R7 outputs low in mid-run reset", {byte_clk, pix_clk}, 0);
    rd(2'd1, d);
    chk(d == 8'd9, "R7 config kept over reset", d, 9);
    @(negedge vco_clk); rst = 1'b0;

    // save and restore
    wr(2'd0, 8'd5); wr(2'd1, 8'h2C); wr(2'd2, 8'h02);
    rd(2'd0, s0); rd(2'd1, s1); rd(2'd2, s2);
    wr(2'd0, 8'd0); wr(2'd1, 8'd1); wr(2'd2, 8'h00);
    settle_measure(1'b0, per, hi);
    chk(per == 4, "R8 changed byte period", per, 4);
    wr(2'd0, s0); wr(2'd1, s1); wr(2'd2, s2);
    rd(2'd0, d); chk(d == 8'd5, "R8 restored byte divider", d, 5);
    rd(2'd1, d); chk(d == 8'h2C, "R8 restored pixel divider", d, 8'h2C);
    rd(2'd2, d); chk(d == 8'h02, "R8 restored select", d, 2);
    settle_measure(1'b1, per, hi);
    chk(per == 45, "R8 restored pixel period", per, 45);
    settle_measure(1'b0, per, hi);
    chk(per == 48, "R8 restored byte period", per, 48);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge vco_clk);
    if (!done) begin
      done = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule